// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache between a 32-bit processor port and a slower main-memory port. Each cache line holds four 32-bit words. The memory port moves a whole 128-bit line in one transfer, and each transfer takes a variable number of cycles. The processor presents a request with a valid signal and holds it until the cache raises ready for one cycle. A read hit returns the selected word. A write hit changes only that word in the cache and marks the line modified, so main memory is not updated until the line is replaced.

On a miss the cache runs a sequence of steps. If the resident line is modified, it first writes the whole line back to memory. It then reads the missing line, and finally retries the pending request, which now hits. A write miss therefore fetches the line first and then merges the new word into it. Memory requests use the same valid/ready handshake as the processor port. A request stays unchanged until memory accepts it, and only one memory transfer is in flight at any time.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid, and cpu_ready and mem_valid are low. The first access to any line is a miss and issues a memory read.
- R2: The address is split as follows. Bits [3:2] select the word in the line, bits [7:4] select one of 16 lines, and bits [31:8] form the stored tag. Bits [1:0] have no effect on the access.
- R3: A read hit raises cpu_ready in the cycle after the request is accepted, with the addressed word on cpu_rdata. It causes no memory transfer, and ready is a single-cycle pulse.
- R4: A write hit replaces only the addressed word, marks the line modified and causes no memory transfer. The other words of the line keep their values.
- R5: A read miss on an invalid line issues one memory read at the line-aligned address {tag, index, 4'b0000}. It then returns the correct word.
- R6: A miss on a modified line first writes the whole 128-bit line to the victim address {stored tag, index, 4'b0000}. Only after that write completes does it read the new line.
- R7: A write miss fetches the line, then merges the written word. The other three words keep their memory values, and the retry after the fill hits.
- R8: cpu_ready stays low while any memory transfer is in progress, until the pending access completes.
- R9: While mem_valid is high and mem_ready is low, mem_addr and mem_we do not change. There is never more than one transfer in flight.
- R10: On the 128-bit memory bus, word w of a line occupies bits [32w+31:32w].
- R11: Replacing an unmodified line issues no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Fetched line, valid with mem_ready on a fetch |
| mem_ready | input | 1 | Memory completes the current request |

## Verification
The bench targets the following corner cases, and each one exposes a specific defect:
- **Write hit:** a write-through bug shows up as an unexpected memory write.
- **Eviction order:** an eviction that fetches before writing back, or writes back to the new tag's address, leaves stale data in the bench's memory model.
- **Write miss:** a write miss that skips the fetch loses the three neighbouring words.
- **Unmodified replacement:** a dirty flag that is not cleared on fill causes a spurious write-back when a clean line is replaced.
- **Latency and alignment:** memory latency is varied between zero and several cycles, and a request that changes before it is accepted is counted as a failure. Offset bits in the low address must select the same word as the aligned address.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COMPARE = 2'd1,
    ST_WBACK   = 2'd2,
    ST_FILL    = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[rd_idx] <= 1'b1;
      dirty_q[rd_idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[rd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[rd_idx] <= fill_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W      = 4,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic [IDX_W-1:0]              idx,
  output logic [WORD_W*LINE_WORDS-1:0]  rd_line,
  input  logic                          fill_en,
  input  logic [WORD_W*LINE_WORDS-1:0]  fill_line,
  input  logic                          word_en,
  input  logic [$clog2(LINE_WORDS)-1:0] word_sel,
  input  logic [WORD_W-1:0]             word_data
);
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;

  logic [LINE_W-1:0] line_q [LINES];
  logic [LINE_W-1:0] merged;

  assign rd_line = line_q[idx];

  // one lane per word: the selected lane takes the new data
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
    assign merged[w*WORD_W +: WORD_W] =
      (word_sel == w[$clog2(LINE_WORDS)-1:0]) ? word_data : rd_line[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (fill_en)      line_q[idx] <= fill_line;
    else if (word_en) line_q[idx] <= merged;
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_valid,
  input  logic       lookup_hit,
  input  logic       victim_dirty,
  input  logic       mem_ready,
  output ctl_state_t state
);
  ctl_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:    if (cpu_valid) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (lookup_hit)        state_d = ST_IDLE;
        else if (victim_dirty) state_d = ST_WBACK;
        else                   state_d = ST_FILL;
      end
      ST_WBACK:   if (mem_ready) state_d = ST_FILL;
      ST_FILL:    if (mem_ready) state_d = ST_COMPARE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_valid,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [WORD_W-1:0]            cpu_wdata,
  output logic [WORD_W-1:0]            cpu_rdata,
  output logic                         cpu_ready,
  output logic                         mem_valid,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [WORD_W*LINE_WORDS-1:0] mem_wdata,
  input  logic [WORD_W*LINE_WORDS-1:0] mem_rdata,
  input  logic                         mem_ready
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int WA_W   = ADDR_W - BYTE_W;

  // address arithmetic on word addresses (byte offset already dropped)
  function automatic logic [OFF_W-1:0] f_word(input logic [WA_W-1:0] wa);
    return wa[OFF_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] f_index(input logic [WA_W-1:0] wa);
    return wa[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [WA_W-1:0] wa);
    return wa[WA_W-1 -: TAG_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_line_base(input logic [TAG_W-1:0] t,
                                                    input logic [IDX_W-1:0] i);
    return {t, i, {(OFF_W + BYTE_W){1'b0}}};
  endfunction

  ctl_state_t        state;
  logic              accept;
  logic [WA_W-1:0]   req_wa_q;
  logic              req_we_q;
  logic [WORD_W-1:0] req_wdata_q;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_word;

  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;

  // named internal events used by the checker
  logic in_compare;
  logic lookup_hit;
  logic victim_dirty;
  logic fill_done;
  logic write_hit;

  logic unused_byte_bits;
  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  assign accept = (state == ST_IDLE) && cpu_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_wa_q    <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
    end else if (accept) begin
      req_wa_q    <= cpu_addr[ADDR_W-1:BYTE_W];
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
    end
  end

  assign req_idx  = f_index(req_wa_q);
  assign req_tag  = f_tag(req_wa_q);
  assign req_word = f_word(req_wa_q);

  assign in_compare   = (state == ST_COMPARE);
  assign lookup_hit   = line_valid && (line_tag == req_tag);
  assign victim_dirty = line_valid && line_dirty;
  assign fill_done    = (state == ST_FILL) && mem_ready;
  assign write_hit    = in_compare && lookup_hit && req_we_q;

  dmc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid    (cpu_valid),
    .lookup_hit   (lookup_hit),
    .victim_dirty (victim_dirty),
    .mem_ready    (mem_ready),
    .state        (state)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (req_idx),
    .rd_valid   (line_valid),
    .rd_dirty   (line_dirty),
    .rd_tag     (line_tag),
    .fill_en    (fill_done),
    .fill_tag   (req_tag),
    .mark_dirty (write_hit)
  );

  dmc_data_store #(.IDX_W(IDX_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk       (clk),
    .idx       (req_idx),
    .rd_line   (line_data),
    .fill_en   (fill_done),
    .fill_line (mem_rdata),
    .word_en   (write_hit),
    .word_sel  (req_word),
    .word_data (req_wdata_q)
  );

  assign cpu_ready = in_compare && lookup_hit;
  assign cpu_rdata = line_data[req_word*WORD_W +: WORD_W];

  assign mem_valid = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = (state == ST_WBACK) ? f_line_base(line_tag, req_idx)
                                         : f_line_base(req_tag, req_idx);
  assign mem_wdata = line_data;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              in_compare,
  input logic              lookup_hit
);
  // R9: request held until accepted
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R6: a completed write-back is followed directly by a line fetch
  assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_ready) |=> (mem_valid && !mem_we));

  // R7: after a fill the retried access hits
  assert_fill_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> cpu_ready);

  // R3: ready is a single-cycle pulse
  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R8: a miss keeps ready low in the following cycle
  assert_miss_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_compare && !lookup_hit) |=> (!cpu_ready && mem_valid));
endmodule

bind dm_wb_cache dmc_checker #(.ADDR_W(ADDR_W)) u_dmc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_ready  (cpu_ready),
  .mem_valid  (mem_valid),
  .mem_we     (mem_we),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .in_compare (in_compare),
  .lookup_hit (lookup_hit)
);

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0;
  logic         cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_wb_cache u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int checks = 0;
  int fails  = 0;

  // ---------------- memory model ----------------
  logic [31:0] mem_arr [MEM_WORDS];
  logic [31:0] exp_arr [MEM_WORDS];
  int lat = 3;
  int cnt = 0;
  int rd_cnt = 0, wr_cnt = 0, seq = 0;
  int last_rd_seq = 0, last_wr_seq = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  int stab_err = 0, ready_in_mem = 0;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;
  logic        prev_we = 1'b0;

  function automatic logic [31:0] init_word(input int i);
    return 32'hC0DE_0000 + i * 7;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      cnt <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
      cnt <= 0;
    end else if (mem_valid) begin
      if (cnt >= lat) begin
        mem_ready <= 1'b1;
        seq <= seq + 1;
        if (mem_we) begin
          for (int w = 0; w < 4; w++)
            mem_arr[mem_addr[11:2] + w] <= mem_wdata[32*w +: 32];
          wr_cnt <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
          last_wr_seq <= seq + 1;
        end else begin
          for (int w = 0; w < 4; w++)
            mem_rdata[32*w +: 32] <= mem_arr[mem_addr[11:2] + w];
          rd_cnt <= rd_cnt + 1;
          last_rd_addr <= mem_addr;
          last_rd_seq <= seq + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  // request stability and stall monitor (R8, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend && (!mem_valid || mem_addr != prev_addr || mem_we != prev_we))
        stab_err <= stab_err + 1;
      if (mem_valid && cpu_ready) ready_in_mem <= ready_in_mem + 1;
      prev_pend <= mem_valid && !mem_ready;
      prev_addr <= mem_addr;
      prev_we   <= mem_we;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_access(input logic we, input logic [31:0] a, input logic [31:0] d,
                            output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_valid = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 300);
    rd = cpu_rdata;
    cpu_valid = 1'b0;
    if (we) exp_arr[a[11:2]] = d;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 ready low after reset", {31'd0, cpu_ready}, 32'd0);
    chk("R1 mem_valid low after reset", {31'd0, mem_valid}, 32'd0);
  endtask

  task automatic t_read_miss();
    logic [31:0] rd; int cyc; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(1'b0, 32'h0000_0104, '0, rd, cyc);
    chk("R1 first access misses (one read)", rd_cnt - r0, 1);
    chk("R5 aligned fetch address", last_rd_addr, 32'h0000_0100);
    chk("R11 no write-back from empty line", wr_cnt - w0, 0);
    chk("R5 miss data", rd, exp_arr[32'h104 >> 2]);
    chk("R8 miss takes more than one cycle", {31'd0, cyc > 2}, 32'd1);
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int cyc; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(1'b0, 32'h0000_0108, '0, rd, cyc);
    chk("R3 hit data", rd, exp_arr[32'h108 >> 2]);
    chk("R3 hit latency", cyc, 1);
    chk("R3 no memory traffic", (rd_cnt - r0) + (wr_cnt - w0), 0);
    cpu_access(1'b0, 32'h0000_010B, '0, rd, cyc);
    chk("R2 byte offset ignored", rd, exp_arr[32'h108 >> 2]);
    cpu_access(1'b0, 32'h0000_010C, '0, rd, cyc);
    chk("R10 word 3 lane", rd, init_word(32'h10C >> 2));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int cyc; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(1'b1, 32'h0000_010C, 32'hDEAD_BEEF, rd, cyc);
    chk("R4 write hit latency", cyc, 1);
    chk("R4 no memory write", (rd_cnt - r0) + (wr_cnt - w0), 0);
    chk("R4 memory untouched", mem_arr[32'h10C >> 2], init_word(32'h10C >> 2));
    cpu_access(1'b0, 32'h0000_010C, '0, rd, cyc);
    chk("R4 read back written word", rd, 32'hDEAD_BEEF);
    cpu_access(1'b0, 32'h0000_0100, '0, rd, cyc);
    chk("R4 neighbour word kept", rd, exp_arr[32'h100 >> 2]);
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int cyc; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(1'b0, 32'h0000_0504, '0, rd, cyc);
    chk("R6 one write-back", wr_cnt - w0, 1);
    chk("R6 victim address", last_wr_addr, 32'h0000_0100);
    chk("R6 write-back before fetch", {31'd0, last_wr_seq < last_rd_seq}, 32'd1);
    chk("R6 one fetch", rd_cnt - r0, 1);
    chk("R10 written word in lane 3", mem_arr[32'h10C >> 2], 32'hDEAD_BEEF);
    chk("R10 lane 0 written back", mem_arr[32'h100 >> 2], init_word(32'h100 >> 2));
    chk("R6 new line data", rd, exp_arr[32'h504 >> 2]);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; int cyc; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(1'b1, 32'h0000_021C, 32'h1234_5678, rd, cyc);
    chk("R7 write miss fetches line", rd_cnt - r0, 1);
    chk("R7 no write-back of invalid line", wr_cnt - w0, 0);
    cpu_access(1'b0, 32'h0000_0214, '0, rd, cyc);
    chk("R7 fetched neighbour kept", rd, init_word(32'h214 >> 2));
    cpu_access(1'b0, 32'h0000_021C, '0, rd, cyc);
    chk("R7 merged word", rd, 32'h1234_5678);
  endtask

  task automatic t_clean_replace();
    logic [31:0] rd; int cyc; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_access(1'b0, 32'h0000_0700, '0, rd, cyc);
    chk("R11 clean victim not written", wr_cnt - w0, 0);
    chk("R11 fetch issued", rd_cnt - r0, 1);
    chk("R5 data after clean replace", rd, exp_arr[32'h700 >> 2]);
  endtask

  task automatic t_latency();
    logic [31:0] rd; int cyc;
    lat = 0;
    cpu_access(1'b1, 32'h0000_0218, 32'hA5A5_0001, rd, cyc);
    lat = 7;
    cpu_access(1'b0, 32'h0000_0318, '0, rd, cyc);
    chk("R9 data with long latency", rd, exp_arr[32'h318 >> 2]);
    chk("R6 evicted word 2", mem_arr[32'h218 >> 2], 32'hA5A5_0001);
    chk("R7 evicted word 3", mem_arr[32'h21C >> 2], 32'h1234_5678);
    lat = 0;
    cpu_access(1'b0, 32'h0000_0204, '0, rd, cyc);
    chk("R9 data with zero latency", rd, 32'hA5A5_0001 == 0 ? 0 : init_word(32'h204 >> 2));
    cpu_access(1'b0, 32'h0000_0218, '0, rd, cyc);
    chk("R9 written value survives round trip", rd, 32'hA5A5_0001);
    chk("R9 request stable until accepted", stab_err, 0);
    chk("R8 no ready during memory transfer", ready_in_mem, 0);
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem_arr[i] = init_word(i);
      exp_arr[i] = init_word(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_read_hit();
    t_write_hit();
    t_dirty_evict();
    t_write_miss();
    t_clean_replace();
    t_latency();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule